// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block switches one output clock between two source clocks that are asynchronous to each other. The output never shows a runt pulse or a glitch. A select bit, normally driven from a control register in the `clk_i` domain, names the wanted source. The block hands the output over in a fixed order:

1. The running source is shut off on its own falling edge.
2. The output stays low while no source is enabled.
3. The new source is let through on its own falling edge.

Each enable crosses into its source clock domain through a two-flop synchronizer. Each enable is also synchronized back into the control domain, so the control logic sees when each step has landed.

A three-bit one-hot status output tells software which source drives the output. It shows a "changing" code while a handover is under way. A handover toward a source that is not toggling never finishes: the status stays in the changing code and the output stays low until that source starts. If the select moves during a handover, the block finishes the current handover and then acts on the latest select value.

Top module: `glitchless_clk_mux`

## Requirements
- R1: After reset, source 0 drives `clk_o` and `status_o` reads 3'b001.
- R2: `status_o` always holds one of three codes: 3'b001 (source 0 active), 3'b010 (source 1 active) or 3'b100 (handover in progress).
- R3: A select value that differs from the active source starts a handover. `status_o` reads 3'b100 within three `clk_i` cycles of the select change.
- R4: When a handover completes, `status_o` names the new source, and `clk_o` runs at that source's frequency.
- R5: No high or low phase of `clk_o` is shorter than the shorter source half-period.
- R6: The old source's enable is seen low before the new source's enable is requested. While neither source is enabled, `clk_o` is held low.
- R7: A handover toward a stopped source stays incomplete. `status_o` stays at 3'b100 and `clk_o` stays low.
- R8: When the stopped target source starts toggling, the pending handover completes without any further select change.
- R9: A select change made during a handover is kept. After the current handover completes, the block switches again toward the latest select value.
- R10: Writing the select to the value of the already active source has no effect: the status stays at that source's code and no handover starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Control clock for the select register and the handover sequencer |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk0_i | input | 1 | Source clock 0 |
| clk1_i | input | 1 | Source clock 1 |
| sel_i | input | 1 | Wanted source: 0 selects clk0_i, 1 selects clk1_i |
| clk_o | output | 1 | Selected clock, glitch free |
| status_o | output | 3 | One-hot status: 001 source 0, 010 source 1, 100 changing |

## Verification
The two sources have unrelated periods (10 ns and 14 ns), so after each settled switch the count of output edges in a fixed window shows which source is really driving the output.

The bench drives the select through these patterns:
- Single switches in both directions. These show the normal handover order.
- Re-writes of the value that is already active. These show that a write with no change is ignored.
- Two or three select toggles within a few cycles. These separate a design that drops a late change from one that keeps it.
- A switch toward a halted source, followed by a restart of that source. This shows both the output held low while the handover is stuck and the completion once the source starts.

A pulse-width monitor on the output watches all of these patterns for runt phases.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  typedef enum logic [2:0] {
    ST_SRC0 = 3'b001,
    ST_SRC1 = 3'b010,
    ST_BUSY = 3'b100
  } sw_status_e;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DROP  = 2'd1,
    SW_RAISE = 2'd2
  } sw_state_e;
endpackage

// File: rtl/clk_sw_sync.sv
// multi-bit level synchronizer into the control domain
module clk_sw_sync #(
  parameter int unsigned         W       = 2,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clk_sw_gate.sv
// per-source enable: sync on rising edge, update on falling edge
module clk_sw_gate #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_EN = 1'b0
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);
  logic [STAGES-1:0] sync_q;
  logic              en_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_EN}};
    else         sync_q <= {sync_q[STAGES-2:0], req_i};
  end

  // enable moves only while the source is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_EN;
    else         en_q <= sync_q[STAGES-1];
  end

  assign en_o   = en_q;
  assign gclk_o = src_clk_i & en_q;
endmodule

// File: rtl/clk_sw_ctrl.sv
module clk_sw_ctrl
  import clk_sw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [1:0] fb_i,
  output logic [1:0] req_o,
  output logic [2:0] status_o
);
  sw_state_e  st_q;
  logic       sel_q, cur_q, tgt_q;
  logic [1:0] req_q;
  sw_status_e stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SW_IDLE;
      sel_q <= 1'b0;
      cur_q <= 1'b0;
      tgt_q <= 1'b0;
      req_q <= 2'b01;
    end else begin
      sel_q <= sel_i;
      unique case (st_q)
        SW_IDLE: if (sel_q != cur_q) begin
          req_q[cur_q] <= 1'b0;
          tgt_q        <= ~cur_q;
          st_q         <= SW_DROP;
        end
        SW_DROP: if (!fb_i[cur_q]) begin
          req_q[tgt_q] <= 1'b1;
          st_q         <= SW_RAISE;
        end
        SW_RAISE: if (fb_i[tgt_q]) begin
          cur_q <= tgt_q;
          st_q  <= SW_IDLE;
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st_q != SW_IDLE) stat = ST_BUSY;
    else if (cur_q)      stat = ST_SRC1;
    else                 stat = ST_SRC0;
  end

  assign req_o    = req_q;
  assign status_o = stat;

  AST_STATUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(status_o)); // R2
  AST_SRC0_HAS_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'b001) |-> (fb_i == 2'b01)); // R4
  AST_SRC1_HAS_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'b010) |-> (fb_i == 2'b10)); // R4
  AST_RAISE1_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o[1]) |-> !fb_i[0]); // R6
  AST_RAISE0_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o[0]) |-> !fb_i[1]); // R6
endmodule

// File: rtl/glitchless_clk_mux.sv
module glitchless_clk_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk0_i,
  input  logic       clk1_i,
  input  logic       sel_i,
  output logic       clk_o,
  output logic [2:0] status_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0] src_clk, req, en, gclk, fb;

  assign src_clk = {clk1_i, clk0_i};

  clk_sw_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .fb_i    (fb),
    .req_o   (req),
    .status_o(status_o)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clk_sw_gate #(
      .STAGES(SYNC_STAGES),
      .RST_EN(g == 0)
    ) i_gate (
      .src_clk_i(src_clk[g]),
      .rst_ni   (rst_ni),
      .req_i    (req[g]),
      .en_o     (en[g]),
      .gclk_o   (gclk[g])
    );
  end

  clk_sw_sync #(
    .W      (NUM_SRC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b01)
  ) i_fb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en),
    .q_o   (fb)
  );

  assign clk_o = |gclk;

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en[0] && en[1])); // R6
endmodule

// File: tb/test_glitchless_clk_mux.sv
`timescale 1ns/1ps
module test_glitchless_clk_mux;
  logic clk_i = 1'b0, rst_ni = 1'b0, clk0 = 1'b0, clk1 = 1'b0, sel = 1'b0;
  logic run1 = 1'b1;
  logic clk_o;
  logic [2:0] status;
  int checks = 0, fails = 0, edges = 0, glitches = 0, stat_bad = 0;
  realtime t_rise = -1.0, t_fall = -1.0;

  glitchless_clk_mux i_glitchless_clk_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk0_i(clk0), .clk1_i(clk1),
    .sel_i(sel), .clk_o(clk_o), .status_o(status)
  );

  always #4 clk_i = ~clk_i;
  always #5 clk0 = ~clk0;
  always begin
    #7;
    if (run1) clk1 = ~clk1;
    else      clk1 = 1'b0;
  end

  always @(posedge clk_o) begin
    edges++;
    if (t_fall >= 0.0 && ($realtime - t_fall) < 4.9) glitches++;
    t_rise = $realtime;
  end
  always @(negedge clk_o) begin
    if (t_rise >= 0.0 && ($realtime - t_rise) < 4.9) glitches++;
    t_fall = $realtime;
  end
  always @(negedge clk_i)
    if (rst_ni && !(status == 3'b001 || status == 3'b010 || status == 3'b100)) stat_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_win(output int n);
    int e0;
    e0 = edges;
    #1400;
    n = edges - e0;
    @(negedge clk_i);
  endtask

  // poll status until value or limit; returns cycles used, -1 on timeout
  task automatic wait_stat(input logic [2:0] v, input int lim, output int cyc);
    cyc = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_i);
      if (status == v) begin cyc = i; break; end
    end
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk_i);
    sel = v;
  endtask

  initial begin
    int n, c;
    bit held;
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int n, c;
    bit held;
    repeat (3) @(negedge clk_i);
    chk(status == 3'b001, "R1 reset status", int'(status), 1);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    count_win(n);
    chk(n >= 139 && n <= 141, "R1 source 0 drives out", n, 140);

    // R10: same value re-written
    held = 1'b1;
    set_sel(1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (status != 3'b001) held = 1'b0;
    end
    chk(held, "R10 no handover on same select", int'(status), 1);

    // R3/R4: 0 -> 1
    set_sel(1'b1);
    wait_stat(3'b100, 3, c);
    chk(c >= 0, "R3 busy after change to 1", int'(status), 4);
    wait_stat(3'b010, 200, c);
    chk(c >= 0, "R4 status source 1", int'(status), 2);
    count_win(n);
    chk(n >= 99 && n <= 101, "R4 source 1 frequency", n, 100);

    held = 1'b1;
    set_sel(1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (status != 3'b010) held = 1'b0;
    end
    chk(held, "R10 no handover on same select 1", int'(status), 2);

    // 1 -> 0
    set_sel(1'b0);
    wait_stat(3'b100, 3, c);
    chk(c >= 0, "R3 busy after change to 0", int'(status), 4);
    wait_stat(3'b001, 200, c);
    chk(c >= 0, "R4 status source 0", int'(status), 1);
    count_win(n);
    chk(n >= 139 && n <= 141, "R4 source 0 frequency", n, 140);

    // R9: back-to-back 0 -> 1 -> 0
    set_sel(1'b1);
    repeat (3) @(negedge clk_i);
    sel = 1'b0;
    wait_stat(3'b010, 200, c);
    chk(c >= 0, "R9 first handover completes", int'(status), 2);
    wait_stat(3'b001, 200, c);
    chk(c >= 0, "R9 late change serviced", int'(status), 1);
    count_win(n);
    chk(n >= 139 && n <= 141, "R9 ends on source 0", n, 140);

    // R9: 0 -> 1 -> 0 -> 1 within a handover
    set_sel(1'b1);
    repeat (2) @(negedge clk_i);
    sel = 1'b0;
    repeat (2) @(negedge clk_i);
    sel = 1'b1;
    repeat (300) @(negedge clk_i);
    chk(status == 3'b010, "R9 latest select wins", int'(status), 2);
    count_win(n);
    chk(n >= 99 && n <= 101, "R9 ends on source 1", n, 100);

    // R7/R8: switch toward a stopped source
    set_sel(1'b0);
    wait_stat(3'b001, 200, c);
    chk(c >= 0, "R7 setup back on source 0", int'(status), 1);
    run1 = 1'b0;
    repeat (5) @(negedge clk_i);
    set_sel(1'b1);
    repeat (300) @(negedge clk_i);
    chk(status == 3'b100, "R7 stuck in progress", int'(status), 4);
    count_win(n);
    chk(n == 0, "R7 no output edges", n, 0);
    chk(clk_o == 1'b0, "R6 output held low", int'(clk_o), 0);
    chk(status == 3'b100, "R7 still in progress", int'(status), 4);
    run1 = 1'b1;
    wait_stat(3'b010, 200, c);
    chk(c >= 0, "R8 completes once source runs", int'(status), 2);
    count_win(n);
    chk(n >= 99 && n <= 101, "R8 source 1 frequency", n, 100);

    set_sel(1'b0);
    wait_stat(3'b001, 200, c);
    chk(c >= 0, "R4 final return to source 0", int'(status), 1);

    chk(glitches == 0, "R5 no short pulse on output", glitches, 0);
    chk(stat_bad == 0, "R2 status codes legal", stat_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule